// File: doc/BRIEF.md
# Paged External Data Memory Bus Master with Programmable Strobe Stretch

This block sits between an 8-bit processor core and off-chip data memory. The core hands it one transfer at a time: a read or a write, a 24-bit target address and, for writes, a data byte. The address is assembled from three byte registers. The top byte is always the data page byte. The lower two bytes come either from the 16-bit data pointer or, in register-indirect mode, from an address-extension byte (middle) and an index register byte (low). The block then drives a non-multiplexed external bus: a 24-bit address, separate output and input data bytes, active-high read and write strobes, and an enable line that tells board-level tri-state buffers when the block is driving the data bus. The block contains no tri-states of its own.

Software sets a 3-bit stretch value, so slow and fast devices can share the same bus. A value N keeps the selected strobe active for N+1 clocks. Address and write data stay fixed for the whole strobe and for one further clock, so the device sees a hold time. The request side uses valid/ready. `req_ready` is high only while the block is idle, and a transfer starts on a clock edge where `req_valid` and `req_ready` are both high. While `req_ready` is low, anything presented on the request port is ignored and never queued. The response is a one-clock `rsp_valid` pulse with the read byte on `rsp_rdata`. The response cannot be stalled, so the requester must accept it in the cycle it appears.

Top module: `xmem_stretch_if`

## Requirements
- R1: After a synchronous active-high reset, `xrd`, `xwr`, `xdout_en` and `rsp_valid` are 0 and `req_ready` is 1.
- R2: With `req_indirect`=0, the transfer drives `xaddr` = {`req_page`, `req_ptr_hi`, `req_ptr_lo`}, with the page byte in bits 23:16.
- R3: With `req_indirect`=1, the transfer drives `xaddr` = {`req_page`, `req_ext_hi`, `req_reg_lo`}.
- R4: With stretch value N (0..7) sampled at acceptance, the selected strobe (`xwr` if `req_write`=1, else `xrd`) is 1 for exactly N+1 consecutive clocks, starting in the cycle right after the accepting edge.
- R5: `xaddr` and, for writes, `xdout` (= `req_wdata`) keep their values for every strobe cycle and for the one clock that follows the strobe.
- R6: For a read, `rsp_rdata` equals the value of `xdin` sampled at the edge that ends the last strobe cycle.
- R7: `rsp_valid` is high for exactly one cycle, N+3 cycles after the accepting edge's cycle, which is one cycle after the hold clock. For a write it is the only response.
- R8: `xdout_en` is 1 from the first strobe cycle through the hold clock of a write, and it is 0 in every cycle of a read.
- R9: `req_ready` is 0 from the cycle after acceptance until `rsp_valid` rises. A request held on the port during that time is not performed: no further strobe follows the response.
- R10: Changing `cfg_stretch` during a transfer has no effect on that transfer's strobe width.
- R11: `xrd` and `xwr` are never 1 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle; request taken on this edge if valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_indirect | input | 1 | 1 = register-indirect address source |
| req_page | input | 8 | Data page byte, address bits 23:16 |
| req_ptr_hi | input | 8 | Data pointer high byte |
| req_ptr_lo | input | 8 | Data pointer low byte |
| req_ext_hi | input | 8 | Address-extension byte for indirect mode |
| req_reg_lo | input | 8 | Index register byte for indirect mode |
| req_wdata | input | 8 | Write data |
| cfg_stretch | input | 3 | Strobe stretch value N (width N+1 clocks) |
| rsp_valid | output | 1 | One-clock completion pulse |
| rsp_rdata | output | 8 | Captured read data |
| xaddr | output | 24 | External address bus |
| xdout | output | 8 | External data out |
| xdin | input | 8 | External data in |
| xdout_en | output | 1 | Enable for external data bus drivers |
| xrd | output | 1 | Read strobe |
| xwr | output | 1 | Write strobe |

## Verification
Transfers are tried with stretch values of 0, 1, 2, 3, 5 and 7. The zero-stretch case shows whether the counter's single-cycle path is handled. The maximum case exposes an off-by-one in the width count or a wrap of the count. Reads and writes alternate between the pointer source and the indirect source with address bytes that differ from each other, which catches swapped or stuck lanes. The external memory model changes `xdin` on every strobe cycle, so a capture one clock early or late returns a different byte. Some transfers also rewrite `cfg_stretch` and hold a second request on the port while the block is busy, which separates a design that latches its settings and ignores requests from one that does not.

// File: rtl/xmem_pkg.sv
package xmem_pkg;
  localparam int unsigned ADDR_LANES = 3;

  typedef enum logic [1:0] {
    XS_IDLE   = 2'd0,
    XS_STROBE = 2'd1,
    XS_HOLD   = 2'd2
  } xs_state_e;

  typedef enum logic {
    SRC_POINTER  = 1'b0,
    SRC_INDIRECT = 1'b1
  } addr_src_e;
endpackage

// File: rtl/xmem_addr_build.sv
module xmem_addr_build
  import xmem_pkg::*;
#(
  parameter int unsigned BYTE_W = 8,
  localparam int unsigned ADDR_W = BYTE_W * ADDR_LANES
) (
  input  addr_src_e           src,
  input  logic [BYTE_W-1:0]   page,
  input  logic [BYTE_W-1:0]   ptr_hi,
  input  logic [BYTE_W-1:0]   ptr_lo,
  input  logic [BYTE_W-1:0]   ext_hi,
  input  logic [BYTE_W-1:0]   reg_lo,
  output logic [ADDR_W-1:0]   addr
);
  // lane 0 = low byte, lane 1 = middle byte, top lane = page
  for (genvar g = 0; g < ADDR_LANES; g++) begin : g_lane
    if (g == 0) begin : g_low
      assign addr[g*BYTE_W +: BYTE_W] = (src == SRC_INDIRECT) ? reg_lo : ptr_lo;
    end else if (g == 1) begin : g_mid
      assign addr[g*BYTE_W +: BYTE_W] = (src == SRC_INDIRECT) ? ext_hi : ptr_hi;
    end else begin : g_page
      assign addr[g*BYTE_W +: BYTE_W] = page;
    end
  end
endmodule

// File: rtl/xmem_seq.sv
module xmem_seq
  import xmem_pkg::*;
#(
  parameter int unsigned STRETCH_W = 3
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 start,
  input  logic                 start_wr,
  input  logic [STRETCH_W-1:0] stretch,
  output logic                 idle,
  output logic                 busy,
  output logic                 rd_q,
  output logic                 wr_q,
  output logic                 oe_q,
  output logic                 capture,
  output logic                 done_q
);
  xs_state_e            state;
  logic [STRETCH_W-1:0] cnt;

  assign idle    = (state == XS_IDLE);
  assign busy    = !idle;
  assign capture = (state == XS_STROBE) && (cnt == '0) && rd_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= XS_IDLE;
      cnt    <= '0;
      rd_q   <= 1'b0;
      wr_q   <= 1'b0;
      oe_q   <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state)
        XS_IDLE: begin
          if (start) begin
            state <= XS_STROBE;
            cnt   <= stretch;
            rd_q  <= !start_wr;
            wr_q  <= start_wr;
            oe_q  <= start_wr;
          end
        end
        XS_STROBE: begin
          if (cnt == '0) begin
            state <= XS_HOLD;
            rd_q  <= 1'b0;
            wr_q  <= 1'b0;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        XS_HOLD: begin
          state  <= XS_IDLE;
          oe_q   <= 1'b0;
          done_q <= 1'b1;
        end
        default: state <= XS_IDLE;
      endcase
    end
  end

  // ---------------- checks kept beside the sequencer ----------------
  logic [STRETCH_W-1:0] len_q;
  logic [STRETCH_W:0]   wcnt;
  always_ff @(posedge clk) begin
    if (rst) begin
      len_q <= '0;
      wcnt  <= '0;
    end else begin
      if (start && idle) len_q <= stretch;
      wcnt <= (rd_q || wr_q) ? wcnt + 1'b1 : '0;
    end
  end

  a_r1_reset_quiet: assert property (@(posedge clk)
    rst |=> (!rd_q && !wr_q && !oe_q && !done_q));

  a_r4_width_bound: assert property (@(posedge clk) disable iff (rst)
    (rd_q || wr_q) |-> (wcnt <= {1'b0, len_q}));

  a_r4_width_exact: assert property (@(posedge clk) disable iff (rst)
    $fell(rd_q || wr_q) |-> ($past(wcnt) == {1'b0, len_q}));

  a_r11_one_strobe: assert property (@(posedge clk) disable iff (rst)
    !(rd_q && wr_q));

  a_r8_no_drive_on_read: assert property (@(posedge clk) disable iff (rst)
    rd_q |-> !oe_q);

  a_r7_single_done: assert property (@(posedge clk) disable iff (rst)
    done_q |=> !done_q);
endmodule

// File: rtl/xmem_datapath.sv
module xmem_datapath #(
  parameter int unsigned ADDR_W = 24,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              busy,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic [DATA_W-1:0] wdata_in,
  input  logic              capture,
  input  logic [DATA_W-1:0] xdin,
  output logic [ADDR_W-1:0] addr_q,
  output logic [DATA_W-1:0] dout_q,
  output logic [DATA_W-1:0] rdata_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q  <= '0;
      dout_q  <= '0;
      rdata_q <= '0;
    end else begin
      if (load) begin
        addr_q <= addr_in;
        dout_q <= wdata_in;
      end
      if (capture) rdata_q <= xdin;
    end
  end

  a_r5_bus_stable: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> ($stable(addr_q) && $stable(dout_q)));
endmodule

// File: rtl/xmem_stretch_if.sv
module xmem_stretch_if
  import xmem_pkg::*;
#(
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned STRETCH_W = 3,
  localparam int unsigned ADDR_W   = DATA_W * ADDR_LANES
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic                 req_write,
  input  logic                 req_indirect,
  input  logic [DATA_W-1:0]    req_page,
  input  logic [DATA_W-1:0]    req_ptr_hi,
  input  logic [DATA_W-1:0]    req_ptr_lo,
  input  logic [DATA_W-1:0]    req_ext_hi,
  input  logic [DATA_W-1:0]    req_reg_lo,
  input  logic [DATA_W-1:0]    req_wdata,
  input  logic [STRETCH_W-1:0] cfg_stretch,
  output logic                 rsp_valid,
  output logic [DATA_W-1:0]    rsp_rdata,
  output logic [ADDR_W-1:0]    xaddr,
  output logic [DATA_W-1:0]    xdout,
  input  logic [DATA_W-1:0]    xdin,
  output logic                 xdout_en,
  output logic                 xrd,
  output logic                 xwr
);
  logic              idle, busy, capture, take;
  logic [ADDR_W-1:0] addr_next;
  addr_src_e         src;

  assign src       = req_indirect ? SRC_INDIRECT : SRC_POINTER;
  assign req_ready = idle;
  assign take      = req_valid && idle;

  xmem_addr_build #(.BYTE_W(DATA_W)) u_addr (
    .src    (src),
    .page   (req_page),
    .ptr_hi (req_ptr_hi),
    .ptr_lo (req_ptr_lo),
    .ext_hi (req_ext_hi),
    .reg_lo (req_reg_lo),
    .addr   (addr_next)
  );

  xmem_seq #(.STRETCH_W(STRETCH_W)) u_seq (
    .clk      (clk),
    .rst      (rst),
    .start    (take),
    .start_wr (req_write),
    .stretch  (cfg_stretch),
    .idle     (idle),
    .busy     (busy),
    .rd_q     (xrd),
    .wr_q     (xwr),
    .oe_q     (xdout_en),
    .capture  (capture),
    .done_q   (rsp_valid)
  );

  xmem_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk      (clk),
    .rst      (rst),
    .load     (take),
    .busy     (busy),
    .addr_in  (addr_next),
    .wdata_in (req_wdata),
    .capture  (capture),
    .xdin     (xdin),
    .addr_q   (xaddr),
    .dout_q   (xdout),
    .rdata_q  (rsp_rdata)
  );

  a_r9_busy_not_ready: assert property (@(posedge clk) disable iff (rst)
    (xrd || xwr) |-> !req_ready);

  a_r9_ignored_when_busy: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_ready && !rsp_valid) |=> !rsp_valid || !(xrd || xwr));
endmodule

// File: tb/xmem_stretch_if_tb_top.sv
module xmem_stretch_if_tb_top;
  logic        clk = 1'b0;
  logic        rst;
  logic        req_valid, req_write, req_indirect;
  logic [7:0]  req_page, req_ptr_hi, req_ptr_lo, req_ext_hi, req_reg_lo, req_wdata;
  logic [2:0]  cfg_stretch;
  logic        req_ready, rsp_valid, xdout_en, xrd, xwr;
  logic [7:0]  rsp_rdata, xdout, xdin;
  logic [23:0] xaddr;

  int n_checks = 0;
  int n_fail   = 0;
  int cyc      = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  xmem_stretch_if dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_indirect(req_indirect), .req_page(req_page),
    .req_ptr_hi(req_ptr_hi), .req_ptr_lo(req_ptr_lo), .req_ext_hi(req_ext_hi),
    .req_reg_lo(req_reg_lo), .req_wdata(req_wdata), .cfg_stretch(cfg_stretch),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .xaddr(xaddr), .xdout(xdout),
    .xdin(xdin), .xdout_en(xdout_en), .xrd(xrd), .xwr(xwr)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 20000);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  // One transfer; poke holds a second request on the port while busy.
  task automatic run_xfer(input bit wr, input bit ind, input logic [7:0] pg,
                          input logic [7:0] hi, input logic [7:0] lo,
                          input logic [7:0] ext, input logic [7:0] rl,
                          input logic [7:0] wd, input int n,
                          input logic [7:0] base, input bit poke);
    logic [23:0] exp_addr;
    int strobe_cnt = 0, other_strobe = 0, addr_bad = 0, dout_bad = 0;
    int oe_bad = 0, ready_bad = 0, early_rsp = 0, width_bad = 0;
    exp_addr = ind ? {pg, ext, rl} : {pg, hi, lo};
    @(negedge clk);
    chk(req_ready == 1'b1, "R9 ready while idle", req_ready, 1);
    req_write = wr; req_indirect = ind; req_page = pg; req_ptr_hi = hi;
    req_ptr_lo = lo; req_ext_hi = ext; req_reg_lo = rl; req_wdata = wd;
    cfg_stretch = 3'(n); req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    cfg_stretch = ~3'(n);                       // R10: late change must not matter
    if (poke) begin
      req_valid = 1'b1; req_page = ~pg; req_write = ~wr; req_wdata = ~wd;
    end
    for (int k = 1; k <= n + 3; k++) begin
      logic s, o;
      s = wr ? xwr : xrd;
      o = wr ? xrd : xwr;
      if (o) other_strobe++;
      if (k <= n + 1) begin
        if (s) strobe_cnt++; else width_bad++;
      end else if (s) width_bad++;
      if (k <= n + 2) begin
        if (xaddr !== exp_addr) addr_bad++;
        if (wr && xdout !== wd) dout_bad++;
        if (xdout_en !== wr) oe_bad++;
        if (req_ready !== 1'b0) ready_bad++;
        if (rsp_valid !== 1'b0) early_rsp++;
      end
      if (k == n + 2 && poke) req_valid = 1'b0;
      if (k == n + 3) begin
        chk(rsp_valid == 1'b1, "R7 done at N+3", rsp_valid, 1);
        if (!wr) chk(rsp_rdata == base + 8'(n), "R6 read capture", rsp_rdata, base + 8'(n));
      end
      xdin = base + 8'(k - 1);
      if (k < n + 3) @(negedge clk);
    end
    chk(strobe_cnt == n + 1 && width_bad == 0, "R4/R10 strobe width", strobe_cnt, n + 1);
    chk(other_strobe == 0, "R11 strobe exclusive", other_strobe, 0);
    chk(addr_bad == 0, ind ? "R3 indirect address" : "R2 direct address", addr_bad, 0);
    chk(dout_bad == 0, "R5 data held", dout_bad, 0);
    chk(oe_bad == 0, "R8 drive enable", oe_bad, 0);
    chk(ready_bad == 0, "R9 busy not ready", ready_bad, 0);
    chk(early_rsp == 0, "R7 no early done", early_rsp, 0);
    @(negedge clk);
    chk(rsp_valid == 1'b0, "R7 one-cycle done", rsp_valid, 0);
    @(negedge clk);
    chk(!xrd && !xwr, "R9 busy request ignored", {xrd, xwr}, 0);
  endtask

  task automatic t_reset;
    rst = 1'b1; req_valid = 1'b0; req_write = 1'b0; req_indirect = 1'b0;
    req_page = '0; req_ptr_hi = '0; req_ptr_lo = '0; req_ext_hi = '0;
    req_reg_lo = '0; req_wdata = '0; cfg_stretch = '0; xdin = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!xrd && !xwr && !xdout_en && !rsp_valid, "R1 outputs idle",
        {xrd, xwr, xdout_en, rsp_valid}, 0);
    chk(req_ready == 1'b1, "R1 ready after reset", req_ready, 1);
  endtask

  task automatic t_read_min;   run_xfer(0, 0, 8'h12, 8'h34, 8'h56, 8'h9A, 8'hBC, 8'h00, 0, 8'h40, 0); endtask
  task automatic t_read_max;   run_xfer(0, 0, 8'hA1, 8'hB2, 8'hC3, 8'h11, 8'h22, 8'h00, 7, 8'h70, 0); endtask
  task automatic t_write_mid;  run_xfer(1, 0, 8'h0F, 8'hF0, 8'h5A, 8'h77, 8'h88, 8'hC6, 3, 8'h00, 0); endtask
  task automatic t_read_ind;   run_xfer(0, 1, 8'h3C, 8'hDE, 8'hAD, 8'h6B, 8'h19, 8'h00, 2, 8'hE0, 0); endtask
  task automatic t_write_ind;  run_xfer(1, 1, 8'hFE, 8'h01, 8'h02, 8'h81, 8'h7E, 8'h3D, 5, 8'h10, 1); endtask
  task automatic t_read_poke;  run_xfer(0, 0, 8'h55, 8'hAA, 8'h0C, 8'h00, 8'h00, 8'h00, 1, 8'h90, 1); endtask

  initial begin
    t_reset();
    t_read_min();
    t_read_max();
    t_write_mid();
    t_read_ind();
    t_write_ind();
    t_read_poke();
    finished = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule